// File: doc/BRIEF.md
# Address-Stability Sleep Controller

This block sits between a memory's address inputs and its array read path. It watches the incoming address and the internal mode status. Once the address has held still long enough, it puts the read path into a low-power sleep state. The stability threshold comes from an input port and is counted in clock cycles. It stands for the access time plus a margin.

While the block sleeps, it turns off the array read enable and keeps the last output word frozen on its data output. Any address change ends sleep in the same cycle. The new word from the array is then loaded at the next clock edge. Sleep is only possible while the internal mode status reports read mode. An automatic algorithm, an erase suspend or a partly received command sequence keeps the block awake and clears the stability count.

The controller has no chip-enable, write-enable or output-enable inputs. Sleep depends only on address stability and mode status.

Top module: `addr_sleep_ctrl`

## Requirements
- R1: Asynchronous reset clears state: `sleep_o` = 0, `rdata_o` = 0, `arr_en_o` = 1, stability count = 0.
- R2: With `mode_i` = 2'b00 (read) and a constant address, `sleep_o` rises at the (T+1)-th rising edge after the edge that captured the address, where T = `thresh_i`.
- R3: An address change before sleep restarts the stability count from zero, so the full T+1 edges are needed again from the new address.
- R4: While asleep, a change on `addr_i` drops `sleep_o` and raises `arr_en_o` in the same cycle, before any clock edge.
- R5: Mode codes 2'b01 (algorithm running), 2'b10 (erase suspend) and 2'b11 (command sequence in progress) each keep `sleep_o` at 0, however long the address holds.
- R6: A non-read `mode_i` while asleep drops `sleep_o` at once and clears the count, so after returning to read mode another T+1 stable edges are needed.
- R7: While `sleep_o` is 1, `rdata_o` holds its value across clock edges, whatever `array_data_i` does.
- R8: While awake, `rdata_o` takes the value of `array_data_i` at each rising edge.
- R9: `thresh_i` is applied live; T = 0 gives sleep one edge after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Address bus from host |
| mode_i | input | 2 | Internal mode status: 00 read, 01 algorithm, 10 erase suspend, 11 command sequence |
| thresh_i | input | CW | Stability threshold in cycles |
| array_data_i | input | DW | Word from the array for the current address |
| arr_addr_o | output | AW | Address forwarded to the array |
| arr_en_o | output | 1 | Array read enable, low while asleep |
| rdata_o | output | DW | Registered output data, frozen while asleep |
| sleep_o | output | 1 | Sleep flag |

## Verification
The bench builds the block with an 8-bit address, an 8-bit data word and a 4-bit count. A threshold of 3 puts the full entry sequence, a restart before entry, and all three blocking mode codes within a few dozen cycles. Switching the threshold to 0 reaches the one-edge entry corner. Changing the address mid-cycle during sleep shows that exit happens before any clock edge.

// File: rtl/addr_sleep_ctrl.sv
module addr_sleep_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [DW-1:0] array_data_i,
  output logic [AW-1:0] arr_addr_o,
  output logic          arr_en_o,
  output logic [DW-1:0] rdata_o,
  output logic          sleep_o
);
  localparam logic [1:0] MODE_READ = 2'b00;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          sleep_q;
  logic [DW-1:0] data_q;

  logic moved, busy;
  assign moved = (addr_i != addr_q);
  assign busy  = (mode_i != MODE_READ);

  assign sleep_o    = sleep_q && !moved && !busy;
  assign arr_en_o   = !sleep_o;
  assign arr_addr_o = addr_i;
  assign rdata_o    = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
      data_q  <= '0;
    end else begin
      addr_q <= addr_i;
      if (moved || busy)
        cnt_q <= '0;
      else if (cnt_q < thresh_i)
        cnt_q <= cnt_q + 1'b1;
      sleep_q <= !moved && !busy && (cnt_q >= thresh_i);
      if (!sleep_o)
        data_q <= array_data_i;
    end
  end

  AST_SLEEP_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> addr_i == $past(addr_i)); // R4
  AST_BUSY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i) != MODE_READ |-> !sleep_o); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_o) |-> $stable(rdata_o)); // R7
  AST_AWAKE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!sleep_o) |-> rdata_o == $past(array_data_i)); // R8
endmodule

// File: tb/tb_addr_sleep_ctrl.sv
module tb_addr_sleep_ctrl;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int NV = 22;

  localparam int V_ADDR[NV] = '{5,5,5,5,5,5,9,9,9,10,10,10,10,10,10,10,10,10,10,10,10,10};
  localparam int V_MODE[NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,2,3,0,0,0,0,0};
  localparam int V_DATA[NV] = '{11,12,13,14,15,16,17,18,19,20,21,22,23,24,25,26,27,28,29,30,31,32};
  localparam int V_SLP [NV] = '{0,0,0,0,1,1,0,0,0,0,0,0,0,1,0,0,0,0,0,0,1,1};
  localparam int V_DOUT[NV] = '{11,12,13,14,15,15,17,18,19,20,21,22,23,24,25,26,27,28,29,30,31,31};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic [CW-1:0] thresh_i = 4'd3;
  logic [DW-1:0] array_data_i = '0;
  logic [AW-1:0] arr_addr_o;
  logic          arr_en_o;
  logic [DW-1:0] rdata_o;
  logic          sleep_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  addr_sleep_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .mode_i(mode_i),
    .thresh_i(thresh_i), .array_data_i(array_data_i),
    .arr_addr_o(arr_addr_o), .arr_en_o(arr_en_o),
    .rdata_o(rdata_o), .sleep_o(sleep_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int a, input int m, input int d);
    addr_i = AW'(a);
    mode_i = 2'(m);
    array_data_i = DW'(d);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(sleep_o == 1'b0, "R1 sleep", int'(sleep_o), 0);
    check(rdata_o == '0, "R1 data", int'(rdata_o), 0);
    check(arr_en_o == 1'b1, "R1 en", int'(arr_en_o), 1);
    rst_n = 1'b1;

    // Table: R2 entry, R3 restart, R5 blocking modes, R6 recount, R7 hold, R8 load
    for (int i = 0; i < NV; i++) begin
      step(V_ADDR[i], V_MODE[i], V_DATA[i]);
      check(int'(sleep_o) == V_SLP[i], $sformatf("R2/R3/R5/R6 sleep row %0d", i),
            int'(sleep_o), V_SLP[i]);
      check(int'(rdata_o) == V_DOUT[i], $sformatf("R7/R8 data row %0d", i),
            int'(rdata_o), V_DOUT[i]);
    end

    // R7: array data changes while asleep, output frozen
    step(10, 0, 99);
    check(sleep_o == 1'b1 && int'(rdata_o) == 31, "R7 hold", int'(rdata_o), 31);

    // R4: immediate exit on address change
    addr_i = 8'd11;
    array_data_i = 8'd40;
    #1;
    check(sleep_o == 1'b0, "R4 sleep drop", int'(sleep_o), 0);
    check(arr_en_o == 1'b1, "R4 enable", int'(arr_en_o), 1);
    check(int'(arr_addr_o) == 11, "R4 addr forward", int'(arr_addr_o), 11);
    @(negedge clk);
    check(int'(rdata_o) == 40, "R8 new data", int'(rdata_o), 40);

    // R5: long busy hold, mode 01
    for (int k = 0; k < 10; k++) begin
      step(11, 1, 50 + k);
      check(sleep_o == 1'b0, "R5 busy hold", int'(sleep_o), 0);
    end

    // R9: threshold 0
    thresh_i = '0;
    step(12, 0, 60);
    check(sleep_o == 1'b0, "R9 capture edge", int'(sleep_o), 0);
    step(12, 0, 61);
    check(sleep_o == 1'b1, "R9 one edge", int'(sleep_o), 1);
    check(int'(rdata_o) == 61, "R9 data", int'(rdata_o), 61);

    // R1: reset while asleep
    rst_n = 1'b0;
    #1;
    check(sleep_o == 1'b0 && arr_en_o == 1'b1, "R1 mid reset", int'(sleep_o), 0);
    check(rdata_o == '0, "R1 mid reset data", int'(rdata_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule